// File: doc/BRIEF.md
# Sector Write-Guard Controller

This block sits on the device side of a serial flash and decides whether a page-level program or erase may go ahead. Two sources can turn protection on. One is an active-low write-guard pin. The other is a software switch that four-byte command frames set and clear. A reset clears the software switch, and it must be set again afterwards. The block also holds a guard map with one bit per protection region. Sector 0 is split into a small head part and a tail part, and every other sector is one region.

The block takes bytes that an upstream shifter has already assembled, framed by an active-low chip select. It decodes only frames of the exact length each command needs. A frame of any other length, or one with the wrong prefix, leaves the state unchanged. Changes on the pin are held back while an internal erase is running. The block outputs the combined protection status and a blocked flag for the page currently presented as the program or erase target.

Top module: `sector_guard`

## Requirements
- R1: While reset is asserted and after it is released, `prot_enabled` is 0, the guard map is all zero, and `blocked` is 0 for every page.
- R2: A frame of exactly the four bytes 3Dh, 2Ah, 7Fh, A9h sets the software switch. `prot_enabled` is 1 after the first clock edge that samples `cs_n` high at the end of the frame.
- R3: A frame of exactly the four bytes 3Dh, 2Ah, 7Fh, 9Ah clears the software switch at the same point in time as R2.
- R4: A frame with the correct bytes but three or five bytes long, or a frame whose first byte is not 3Dh, has no effect.
- R5: With `wp_n` low and no erase running, `prot_enabled` is 1 whatever the software switch holds. The pin passes through `WP_SYNC_STAGES` flops and one state flop, so the status follows the pin WP_SYNC_STAGES+1 edges after it changes. When the pin goes high again, the status returns to the software switch.
- R6: While `erase_busy` is high, a change on the synchronised pin level, in either direction, does not reach `prot_enabled`. It takes effect on the first edge that samples `erase_busy` low.
- R7: A four-byte frame 3Dh, 2Ah, 7Fh, CFh sets every guard-map bit to 1.
- R8: A frame of 3Dh, 2Ah, 7Fh, FCh followed by exactly NREG data bytes loads the guard map. Data byte i is for region i. A nonzero byte marks the region guarded and 00h clears it. A frame of any other length leaves the map unchanged.
- R9: Regions are mapped as follows. Pages of sector 0 below SUB0_PAGES use region 0. The remaining pages of sector 0 use region 1. Sector s ≥ 1 uses region s+1. A sector is PAGES_PER_SECTOR pages.
- R10: `blocked` equals `prot_enabled` AND the map bit of the region holding `target_page`. It follows `target_page` in the same cycle.
- R11: Switching protection on or off, by software or by the pin, does not change the guard map.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (power cycle) |
| cs_n | input | 1 | Active-low frame select |
| byte_valid | input | 1 | A command byte is present this cycle |
| byte_data | input | 8 | Command byte |
| wp_n | input | 1 | Active-low write-guard pin |
| erase_busy | input | 1 | Internal erase in progress |
| target_page | input | PAGE_W | Page of the pending program or erase |
| prot_enabled | output | 1 | Combined protection status bit |
| blocked | output | 1 | Target page lies in a guarded region while protection is on |

## Verification
Command frames act on the first rising edge that sees `cs_n` high after the last byte. The bench therefore raises `cs_n`, waits one falling edge and samples there. A pin change needs WP_SYNC_STAGES+1 edges, so the bench samples once an edge before that point, to see the old value, and once at that point, to see the new one. Erase deferral is checked by holding `erase_busy` for several cycles and then sampling one falling edge after it drops. `blocked` is combinational from `target_page`, so it is sampled in the same half-cycle in which the page is changed.

// File: rtl/sg_pkg.sv
package sg_pkg;
   localparam logic [7:0] PFX0        = 8'h3D;
   localparam logic [7:0] PFX1        = 8'h2A;
   localparam logic [7:0] PFX2        = 8'h7F;
   localparam logic [7:0] OP_SW_ON    = 8'hA9;
   localparam logic [7:0] OP_SW_OFF   = 8'h9A;
   localparam logic [7:0] OP_MAP_ERA  = 8'hCF;
   localparam logic [7:0] OP_MAP_PROG = 8'hFC;
   localparam int         HDR_LEN     = 4;

   typedef enum logic [2:0] {
      CMD_NONE,
      CMD_SW_ON,
      CMD_SW_OFF,
      CMD_MAP_ERASE,
      CMD_MAP_PROG
   } cmd_e;
endpackage

// File: rtl/sg_frame_rx.sv
module sg_frame_rx
   import sg_pkg::*;
#(
   parameter int NREG = 9
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cs_n,
   input  logic            byte_valid,
   input  logic [7:0]      byte_data,
   output cmd_e            cmd,
   output logic [NREG-1:0] stage
);
   localparam int MAXLEN = HDR_LEN + NREG;
   localparam int CNT_W  = $clog2(MAXLEN + 2);
   localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(MAXLEN + 1);
   localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(HDR_LEN);
   localparam logic [CNT_W-1:0] CNT_PROG = CNT_W'(MAXLEN);

   logic [CNT_W-1:0] cnt_q;
   logic             cs_n_q;
   logic [7:0]       hdr_q [HDR_LEN];
   logic             take;

   assign take = byte_valid && !cs_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         cs_n_q <= 1'b1;
      end else begin
         cs_n_q <= cs_n;
         if (cs_n)
            cnt_q <= '0;
         else if (take && cnt_q != CNT_SAT)
            cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   for (genvar h = 0; h < HDR_LEN; h++) begin : g_hdr
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            hdr_q[h] <= '0;
         else if (take && cnt_q == CNT_W'(h))
            hdr_q[h] <= byte_data;
      end
   end

   for (genvar r = 0; r < NREG; r++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            stage[r] <= 1'b0;
         else if (take && cnt_q == CNT_W'(HDR_LEN + r))
            stage[r] <= |byte_data;
      end
   end

   logic cs_rise, prefix_ok;
   assign cs_rise   = cs_n && !cs_n_q;
   assign prefix_ok = hdr_q[0] == PFX0 && hdr_q[1] == PFX1 && hdr_q[2] == PFX2;

   always_comb begin
      cmd = CMD_NONE;
      if (cs_rise && prefix_ok) begin
         if (cnt_q == CNT_HDR) begin
            unique case (hdr_q[3])
               OP_SW_ON:   cmd = CMD_SW_ON;
               OP_SW_OFF:  cmd = CMD_SW_OFF;
               OP_MAP_ERA: cmd = CMD_MAP_ERASE;
               default:    cmd = CMD_NONE;
            endcase
         end else if (cnt_q == CNT_PROG && hdr_q[3] == OP_MAP_PROG) begin
            cmd = CMD_MAP_PROG;
         end
      end
   end
endmodule

// File: rtl/sg_prot_state.sv
module sg_prot_state
   import sg_pkg::*;
#(
   parameter int WP_SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  cmd_e cmd,
   input  logic wp_n,
   input  logic erase_busy,
   output logic wp_lvl,
   output logic prot_enabled
);
   logic sw_q, hw_q;

   if (WP_SYNC_STAGES == 0) begin : g_nosync
      assign wp_lvl = ~wp_n;
   end else begin : g_sync
      logic [WP_SYNC_STAGES:0] chain;
      assign chain[0] = ~wp_n;
      for (genvar s = 0; s < WP_SYNC_STAGES; s++) begin : g_ff
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s+1] <= 1'b0;
            else        chain[s+1] <= chain[s];
         end
      end
      assign wp_lvl = chain[WP_SYNC_STAGES];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sw_q <= 1'b0;
         hw_q <= 1'b0;
      end else begin
         if (cmd == CMD_SW_ON)       sw_q <= 1'b1;
         else if (cmd == CMD_SW_OFF) sw_q <= 1'b0;
         if (!erase_busy)            hw_q <= wp_lvl;
      end
   end

   assign prot_enabled = sw_q | hw_q;
endmodule

// File: rtl/sg_region_map.sv
module sg_region_map
   import sg_pkg::*;
#(
   parameter int NUM_PAGES        = 2048,
   parameter int PAGES_PER_SECTOR = 256,
   parameter int SUB0_PAGES       = 8,
   parameter int NREG             = 9,
   parameter int PAGE_W           = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  cmd_e              cmd,
   input  logic [NREG-1:0]   stage,
   input  logic [PAGE_W-1:0] target_page,
   input  logic              prot_enabled,
   output logic [NREG-1:0]   map_q,
   output logic              blocked
);
   localparam int SEC_SH = $clog2(PAGES_PER_SECTOR);
   localparam int SECT_W = PAGE_W - SEC_SH;
   localparam int IDX_W  = $clog2(NREG);
   localparam logic [PAGE_W-1:0] SUB0_L = PAGE_W'(SUB0_PAGES);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     map_q <= '0;
      else if (cmd == CMD_MAP_ERASE)  map_q <= '1;
      else if (cmd == CMD_MAP_PROG)   map_q <= stage;
   end

   logic [SECT_W-1:0] sector;
   logic [IDX_W-1:0]  idx;
   assign sector = target_page[PAGE_W-1:SEC_SH];

   always_comb begin
      if (sector == '0)
         idx = (target_page < SUB0_L) ? IDX_W'(0) : IDX_W'(1);
      else
         idx = IDX_W'(sector) + IDX_W'(1);
   end

   assign blocked = prot_enabled && map_q[idx];
endmodule

// File: rtl/sector_guard.sv
module sector_guard
   import sg_pkg::*;
#(
   parameter int NUM_PAGES        = 2048,
   parameter int PAGES_PER_SECTOR = 256,
   parameter int SUB0_PAGES       = 8,
   parameter int WP_SYNC_STAGES   = 2,
   localparam int PAGE_W          = $clog2(NUM_PAGES),
   localparam int NREG            = NUM_PAGES / PAGES_PER_SECTOR + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              byte_valid,
   input  logic [7:0]        byte_data,
   input  logic              wp_n,
   input  logic              erase_busy,
   input  logic [PAGE_W-1:0] target_page,
   output logic              prot_enabled,
   output logic              blocked
);
   initial begin
      assert ((1 << PAGE_W) == NUM_PAGES)
         else $error("NUM_PAGES must be a power of two");
      assert ((1 << $clog2(PAGES_PER_SECTOR)) == PAGES_PER_SECTOR)
         else $error("PAGES_PER_SECTOR must be a power of two");
      assert (NUM_PAGES >= 2 * PAGES_PER_SECTOR)
         else $error("need at least two sectors");
      assert (SUB0_PAGES > 0 && SUB0_PAGES < PAGES_PER_SECTOR)
         else $error("SUB0_PAGES must split sector 0");
      assert (WP_SYNC_STAGES >= 0 && WP_SYNC_STAGES <= 4)
         else $error("WP_SYNC_STAGES out of range");
   end

   cmd_e            cmd;
   logic [NREG-1:0] stage;
   logic [NREG-1:0] map_q;
   logic            wp_lvl;

   sg_frame_rx #(.NREG(NREG)) u_rx (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .byte_valid(byte_valid),
      .byte_data(byte_data), .cmd(cmd), .stage(stage)
   );

   sg_prot_state #(.WP_SYNC_STAGES(WP_SYNC_STAGES)) u_state (
      .clk(clk), .rst_n(rst_n), .cmd(cmd), .wp_n(wp_n),
      .erase_busy(erase_busy), .wp_lvl(wp_lvl), .prot_enabled(prot_enabled)
   );

   sg_region_map #(
      .NUM_PAGES(NUM_PAGES), .PAGES_PER_SECTOR(PAGES_PER_SECTOR),
      .SUB0_PAGES(SUB0_PAGES), .NREG(NREG), .PAGE_W(PAGE_W)
   ) u_map (
      .clk(clk), .rst_n(rst_n), .cmd(cmd), .stage(stage),
      .target_page(target_page), .prot_enabled(prot_enabled),
      .map_q(map_q), .blocked(blocked)
   );
endmodule

// File: rtl/sg_guard_chk.sv
module sg_guard_chk
   import sg_pkg::*;
#(
   parameter int NREG = 9
) (
   input logic            clk,
   input logic            rst_n,
   input logic            erase_busy,
   input logic            wp_lvl,
   input cmd_e            cmd,
   input logic [NREG-1:0] map_q,
   input logic            prot_enabled,
   input logic            blocked
);
   always @(negedge clk) begin
      if (!rst_n) begin
         AST_RESET_QUIET: assert (!prot_enabled && !blocked && map_q == '0); // R1
      end
   end

   AST_SW_ON_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      cmd == CMD_SW_ON |=> prot_enabled); // R2

   AST_PIN_FORCES: assert property (@(posedge clk) disable iff (!rst_n)
      (wp_lvl && !erase_busy) |=> prot_enabled); // R5

   AST_ERASE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (erase_busy && cmd == CMD_NONE) |=> $stable(prot_enabled)); // R6

   AST_MAP_ALL_SET: assert property (@(posedge clk) disable iff (!rst_n)
      cmd == CMD_MAP_ERASE |=> (&map_q)); // R7

   AST_MAP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd != CMD_MAP_ERASE && cmd != CMD_MAP_PROG) |=> $stable(map_q)); // R11
endmodule

bind sector_guard sg_guard_chk #(.NREG(NREG)) u_chk (
   .clk(clk), .rst_n(rst_n), .erase_busy(erase_busy), .wp_lvl(wp_lvl),
   .cmd(cmd), .map_q(map_q), .prot_enabled(prot_enabled), .blocked(blocked)
);

// File: tb/sector_guard_tb.sv
module sector_guard_tb;
   localparam int STAGES = 2;
   localparam int NREG   = 9;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1;
   logic        byte_valid = 1'b0;
   logic [7:0]  byte_data = '0;
   logic        wp_n = 1'b1;
   logic        erase_busy = 1'b0;
   logic [10:0] target_page = '0;
   logic        prot_enabled, blocked;

   int n_chk = 0;
   int n_bad = 0;
   logic [7:0] fb [16];

   always #10 clk = ~clk;

   sector_guard #(.WP_SYNC_STAGES(STAGES)) u_dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .byte_valid(byte_valid),
      .byte_data(byte_data), .wp_n(wp_n), .erase_busy(erase_busy),
      .target_page(target_page), .prot_enabled(prot_enabled), .blocked(blocked)
   );

   task automatic check(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0b expected %0b", req, act, exp);
      end
   endtask

   task automatic send(input int n);
      @(negedge clk);
      cs_n = 1'b0;
      for (int i = 0; i < n; i++) begin
         byte_valid = 1'b1;
         byte_data  = fb[i];
         @(negedge clk);
      end
      byte_valid = 1'b0;
      cs_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic hdr(input logic [7:0] op);
      fb[0] = 8'h3D; fb[1] = 8'h2A; fb[2] = 8'h7F; fb[3] = op;
   endtask

   task automatic blk(input string req, input int page, input logic exp);
      target_page = 11'(page);
      #1;
      check(req, blocked, exp);
   endtask

   task automatic t_reset;
      check("R1 prot after reset", prot_enabled, 1'b0);
      blk("R1 blocked page 0", 0, 1'b0);
      blk("R1 blocked page 300", 300, 1'b0);
   endtask

   task automatic t_erase_map_and_enable;
      hdr(8'hCF); send(4);
      check("R10 prot still off after map erase", prot_enabled, 1'b0);
      blk("R10 no block while off", 5, 1'b0);
      hdr(8'hA9); send(4);
      check("R2 enable frame", prot_enabled, 1'b1);
      blk("R7 all regions guarded page 5", 5, 1'b1);
      blk("R7 all regions guarded page 2047", 2047, 1'b1);
   endtask

   task automatic t_bad_frames;
      hdr(8'h9A); send(3);
      check("R4 short disable ignored", prot_enabled, 1'b1);
      hdr(8'h9A); fb[4] = 8'h00; send(5);
      check("R4 long disable ignored", prot_enabled, 1'b1);
      hdr(8'h9A); send(4);
      check("R3 disable frame", prot_enabled, 1'b0);
      hdr(8'hA9); fb[0] = 8'h3E; send(4);
      check("R4 bad prefix ignored", prot_enabled, 1'b0);
   endtask

   task automatic t_map_prog;
      hdr(8'hFC);
      fb[4] = 8'hFF; fb[5] = 8'h00; fb[6] = 8'h00; fb[7] = 8'hFF; fb[8] = 8'h00;
      fb[9] = 8'h00; fb[10] = 8'h00; fb[11] = 8'h00; fb[12] = 8'h01;
      send(4 + NREG);
      hdr(8'hA9); send(4);
      blk("R9 page 3 in head region", 3, 1'b1);
      blk("R9 page 8 in tail region", 8, 1'b0);
      blk("R9 page 255 in tail region", 255, 1'b0);
      blk("R9 page 256 sector 1", 256, 1'b0);
      blk("R8 page 512 sector 2 guarded", 512, 1'b1);
      blk("R8 nonzero byte guards page 2047", 2047, 1'b1);
      blk("R8 page 1024 clear", 1024, 1'b0);
      hdr(8'hFC);
      for (int i = 4; i < 4 + NREG - 1; i++) fb[i] = 8'hFF;
      send(4 + NREG - 1);
      blk("R8 short program frame ignored", 8, 1'b0);
      hdr(8'h9A); send(4);
      blk("R10 guarded region unblocked when off", 3, 1'b0);
      hdr(8'hA9); send(4);
      blk("R11 map kept across toggle", 512, 1'b1);
      hdr(8'h9A); send(4);
   endtask

   task automatic t_pin;
      @(negedge clk);
      wp_n = 1'b0;
      for (int i = 0; i < STAGES; i++) @(negedge clk);
      check("R5 pin not yet applied", prot_enabled, 1'b0);
      @(negedge clk);
      check("R5 pin applied", prot_enabled, 1'b1);
      blk("R5 pin guards page 512", 512, 1'b1);
      hdr(8'h9A); send(4);
      check("R5 software off cannot override pin", prot_enabled, 1'b1);
      wp_n = 1'b1;
      for (int i = 0; i <= STAGES; i++) @(negedge clk);
      check("R5 pin release", prot_enabled, 1'b0);
      blk("R11 map intact after pin", 512, 1'b0);
      hdr(8'hA9); send(4);
      blk("R11 map intact after pin, on", 512, 1'b1);
      hdr(8'h9A); send(4);
   endtask

   task automatic t_erase_defer;
      @(negedge clk);
      erase_busy = 1'b1;
      wp_n = 1'b0;
      repeat (6) @(negedge clk);
      check("R6 pin held off during erase", prot_enabled, 1'b0);
      erase_busy = 1'b0;
      @(negedge clk);
      check("R6 pin applied after erase", prot_enabled, 1'b1);
      erase_busy = 1'b1;
      wp_n = 1'b1;
      repeat (6) @(negedge clk);
      check("R6 release held during erase", prot_enabled, 1'b1);
      erase_busy = 1'b0;
      @(negedge clk);
      check("R6 release applied after erase", prot_enabled, 1'b0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1;
      check("R1 prot during reset", prot_enabled, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_erase_map_and_enable();
      t_bad_frames();
      t_map_prog();
      t_pin();
      t_erase_defer();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule